// File: doc/BRIEF.md
# Dual-Tone Sine Generator

This block synthesizes a two-frequency audio signal of the kind used for telephone keypad signalling. It produces unsigned 8-bit samples for a digital-to-analog converter. A divider derived from the system clock sets a fixed sample rate. On every sample tick, each of two phase accumulators advances by its own programmable increment. The upper bits of each accumulator select an entry in one shared table, which holds a full signed sine period.

If both tones are enabled, each table value is halved before the two are added, so the sum always fits in 8 signed bits. If only one tone is enabled, its value is passed through at full scale. The signed result is converted to offset binary by inverting its top bit. A sample computed on one tick is presented on the output at the following tick, and a one-cycle valid strobe marks it there.

The increment for a tone of frequency f is f·65536 / sample rate, truncated. With a 22.1184 MHz clock and a 100 kHz sample rate the divider is 221. Enables and increments are plain inputs, and the block samples them at each tick.

Top module: `dtone_gen`

## Requirements
- R1: Synchronous active-high reset sets the output to 0x80, holds the strobe low, zeroes both accumulators and restarts the tick divider.
- R2: A sample tick occurs every TICK_DIV clocks. The first tick is on the TICK_DIV-th rising edge after reset is released. The valid strobe is never high except in the cycle right after a tick edge.
- R3: On a tick, an enabled tone's 16-bit accumulator adds its increment modulo 65536. A disabled tone's accumulator keeps its phase.
- R4: The table index is accumulator bits 15:8. Entry i holds round(127·sin(2πi/256)) as a signed 8-bit value, so index 64 gives 0x7F, index 192 gives 0x81, and indices 0 and 128 give 0.
- R5: With both tones enabled, the sample is floor(a/2) + floor(b/2) + 128, where a and b are the two table values. The result is always in the range 0 to 255.
- R6: With exactly one tone enabled, the sample is that tone's table value + 128, with no halving.
- R7: With no tone enabled, no accumulator advances and no sample is computed. At the next tick the output keeps its value and the strobe stays low.
- R8: The sample formed from the accumulators updated at tick k appears on the output at tick k+1, with the strobe high for that one cycle.
- R9: Enable and increment changes made between ticks take effect at the next tick without resetting any accumulator phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_en | input | 1 | Enable for the low-group tone |
| hi_en | input | 1 | Enable for the high-group tone |
| lo_inc | input | 16 | Phase increment of the low-group tone |
| hi_inc | input | 16 | Phase increment of the high-group tone |
| dac_out | output | 8 | Offset-binary sample for the converter |
| dac_valid | output | 1 | One-cycle strobe when dac_out is loaded |

## Verification
The bench counts rising edges since reset is released. It treats every multiple of TICK_DIV as a tick edge and samples at the falling edge that follows. At that point the strobe and output must show the sample the bench model formed at the previous tick, using the inputs it held just before that edge. On every other falling edge the strobe must be low and the output unchanged. Because of this, a sample that arrives one cycle early or one tick late is caught as a mismatch.

// File: rtl/dtone_pkg.sv
package dtone_pkg;

  localparam int SAMP_W   = 8;
  localparam int AMP      = (1 << (SAMP_W - 1)) - 1;
  localparam int FRAC     = 30;
  localparam longint PI_FX = 64'sd3373259426;

  typedef enum logic [1:0] {
    M_NONE = 2'b00,
    M_LO   = 2'b01,
    M_HI   = 2'b10,
    M_BOTH = 2'b11
  } tone_mode_e;

  // Signed sine entry for a table of 2**aw points, scaled to amp.
  // Quarter-wave folding plus a fixed-point Taylor series.
  function automatic int sine_entry(int idx, int aw, int amp);
    longint n;
    longint half;
    longint quarter;
    longint i;
    longint q;
    longint x;
    longint term;
    longint sum;
    longint r;
    bit     neg;
    n       = longint'(1) << aw;
    half    = n / 2;
    quarter = n / 4;
    i       = longint'(idx) % n;
    neg     = (i >= half);
    if (neg) i = i - half;
    q       = (i > quarter) ? (half - i) : i;
    x       = (q * PI_FX) / half;
    term    = x;
    sum     = x;
    for (int k = 1; k <= 8; k++) begin
      term = -((((term * x) >>> FRAC) * x) >>> FRAC) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    r = (longint'(amp) * sum + (longint'(1) << (FRAC - 1))) >>> FRAC;
    return neg ? -int'(r) : int'(r);
  endfunction

  // Combine two signed table values according to the mode and convert
  // the signed result to offset binary.
  function automatic logic [SAMP_W-1:0] mix_sample(
    logic signed [SAMP_W-1:0] a,
    logic signed [SAMP_W-1:0] b,
    tone_mode_e               m
  );
    logic signed [SAMP_W-1:0] s;
    case (m)
      M_BOTH:  s = (a >>> 1) + (b >>> 1);
      M_LO:    s = a;
      M_HI:    s = b;
      default: s = '0;
    endcase
    return s ^ {1'b1, {(SAMP_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/dtone_tick_gen.sv
module dtone_tick_gen #(
  parameter int DIV = 221
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2: a tick never lasts two cycles
  a_r2_single_cycle_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: the divider wraps back to zero after the tick
  a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

endmodule

// File: rtl/dtone_phase_acc.sv
module dtone_phase_acc #(
  parameter int ACC_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic [IDX_W-1:0] idx
);
  logic [ACC_W-1:0] acc;
  logic             step_w;

  assign step_w = tick && en;

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (step_w) acc <= acc + inc;
  end

  assign idx = acc[ACC_W-1 -: IDX_W];

  // R3: an enabled tick adds the increment modulo 2**ACC_W
  a_r3_step_adds_inc: assert property (@(posedge clk) disable iff (rst)
    step_w |=> (acc == ACC_W'($past(acc) + $past(inc))));

  // R3, R7: without an enabled tick the phase is kept
  a_r3_phase_kept: assert property (@(posedge clk) disable iff (rst)
    !step_w |=> $stable(acc));

endmodule

// File: rtl/dtone_sine_rom.sv
module dtone_sine_rom
  import dtone_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NPORT  = 2
) (
  input  logic                        clk,
  input  logic [NPORT*ADDR_W-1:0]     addr,
  output logic [NPORT*SAMP_W-1:0]     data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam int VAL = sine_entry(g, ADDR_W, AMP);
    assign tbl[g] = SAMP_W'(VAL);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      data[p*SAMP_W +: SAMP_W] <= tbl[addr[p*ADDR_W +: ADDR_W]];
    end
  end

endmodule

// File: rtl/dtone_mixer.sv
module dtone_mixer
  import dtone_pkg::*;
(
  input  logic signed [SAMP_W-1:0] lo_val,
  input  logic signed [SAMP_W-1:0] hi_val,
  input  tone_mode_e               mode,
  output logic        [SAMP_W-1:0] sample
);
  always_comb sample = mix_sample(lo_val, hi_val, mode);
endmodule

// File: rtl/dtone_gen.sv
module dtone_gen
  import dtone_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int TICK_DIV = 221
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic [ACC_W-1:0]  lo_inc,
  input  logic [ACC_W-1:0]  hi_inc,
  output logic [SAMP_W-1:0] dac_out,
  output logic              dac_valid
);
  localparam int NTONE = 2;

  logic                     tick_w;
  logic [NTONE-1:0]         en_v;
  logic [ACC_W-1:0]         inc_v [NTONE];
  logic [NTONE*ADDR_W-1:0]  idx_bus;
  logic [NTONE*SAMP_W-1:0]  rom_bus;
  logic [SAMP_W-1:0]        mix_w;
  tone_mode_e               mode_q;
  logic                     s1_v;
  logic                     s2_v;
  logic [SAMP_W-1:0]        pend;
  logic                     pend_full;

  assign en_v     = {hi_en, lo_en};
  assign inc_v[0] = lo_inc;
  assign inc_v[1] = hi_inc;

  dtone_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w)
  );

  for (genvar g = 0; g < NTONE; g++) begin : g_tone
    dtone_phase_acc #(.ACC_W(ACC_W), .IDX_W(ADDR_W)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_w),
      .en   (en_v[g]),
      .inc  (inc_v[g]),
      .idx  (idx_bus[g*ADDR_W +: ADDR_W])
    );
  end

  dtone_sine_rom #(.ADDR_W(ADDR_W), .NPORT(NTONE)) u_rom (
    .clk  (clk),
    .addr (idx_bus),
    .data (rom_bus)
  );

  dtone_mixer u_mix (
    .lo_val (rom_bus[0 +: SAMP_W]),
    .hi_val (rom_bus[SAMP_W +: SAMP_W]),
    .mode   (mode_q),
    .sample (mix_w)
  );

  // Stage tracking: tick edge -> table read -> mix into pending slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_NONE;
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
    end else begin
      if (tick_w) mode_q <= tone_mode_e'(en_v);
      s1_v <= tick_w && (|en_v);
      s2_v <= s1_v;
    end
  end

  // Pending sample waits for the next tick before it reaches the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      pend_full <= 1'b0;
      dac_out   <= {1'b1, {(SAMP_W-1){1'b0}}};
      dac_valid <= 1'b0;
    end else begin
      if (s2_v) begin
        pend      <= mix_w;
        pend_full <= 1'b1;
      end else if (tick_w) begin
        pend_full <= 1'b0;
      end
      if (tick_w) begin
        dac_valid <= pend_full;
        if (pend_full) dac_out <= pend;
      end else begin
        dac_valid <= 1'b0;
      end
    end
  end

  // R8: the strobe follows a tick edge only
  a_r8_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    dac_valid |-> $past(tick_w));

  // R7, R8: the output moves only together with the strobe
  a_r7_out_holds: assert property (@(posedge clk) disable iff (rst)
    !dac_valid |-> (dac_out == $past(dac_out)));

  // R8: a sample is mixed before the following tick arrives
  a_r8_mix_before_tick: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> !tick_w);

endmodule

// File: tb/dtone_gen_tb_top.sv
`timescale 1ns/1ps
module dtone_gen_tb_top;
  localparam int DIV = 221;

  logic        clk = 1'b0;
  logic        rst;
  logic        lo_en, hi_en;
  logic [15:0] lo_inc, hi_inc;
  wire  [7:0]  dac_out;
  wire         dac_valid;

  always #2.5 clk = ~clk;

  dtone_gen #(.ACC_W(16), .ADDR_W(8), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .lo_en(lo_en), .hi_en(hi_en),
    .lo_inc(lo_inc), .hi_inc(hi_inc),
    .dac_out(dac_out), .dac_valid(dac_valid)
  );

  int    checks = 0;
  int    fails  = 0;
  int    e      = 0;
  bit    finished = 0;
  string req = "R5";

  logic [15:0] m_alo, m_ahi;
  logic [7:0]  m_out, m_pend;
  bit          m_pv;

  function automatic int sine_ref(int i);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * i / 256.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int half_floor(int v);
    return (v < 0) ? -((-v + 1) / 2) : v / 2;
  endfunction

  function automatic logic [15:0] inc_of(int f);
    return 16'((longint'(f) * 65536) / 100000);
  endfunction

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at edge %0d", r, act, exp, e);
    end
  endtask

  task automatic model_tick();
    int a, b;
    case ({lo_en, hi_en})
      2'b11: begin
        m_alo += lo_inc; m_ahi += hi_inc;
        a = sine_ref(int'(m_alo[15:8])); b = sine_ref(int'(m_ahi[15:8]));
        m_pend = 8'(half_floor(a) + half_floor(b) + 128); m_pv = 1;
      end
      2'b10: begin
        m_alo += lo_inc;
        m_pend = 8'(sine_ref(int'(m_alo[15:8])) + 128); m_pv = 1;
      end
      2'b01: begin
        m_ahi += hi_inc;
        m_pend = 8'(sine_ref(int'(m_ahi[15:8])) + 128); m_pv = 1;
      end
      default: m_pv = 0;
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst) e++;
    @(negedge clk);
    if (!rst) begin
      if (e % DIV == 0) begin
        if (m_pv) begin
          check({req, " R8 strobe at tick"}, {7'b0, dac_valid}, 8'h01);
          check({req, " R8 sample"}, dac_out, m_pend);
          m_out = m_pend;
        end else begin
          check("R7 no strobe", {7'b0, dac_valid}, 8'h00);
          check("R7 output held", dac_out, m_out);
        end
        model_tick();
      end else begin
        check("R2 no strobe between ticks", {7'b0, dac_valid}, 8'h00);
        check("R2 output stable between ticks", dac_out, m_out);
      end
    end
  endtask

  task automatic run_ticks(int n);
    repeat (n * DIV) step();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    check("R1 reset output", dac_out, 8'h80);
    check("R1 reset strobe", {7'b0, dac_valid}, 8'h00);
    rst = 1'b0;
    e = 0; m_alo = '0; m_ahi = '0; m_out = 8'h80; m_pend = '0; m_pv = 0;
  endtask

  task automatic set_tones(bit le, bit he, logic [15:0] li, logic [15:0] hi, string r);
    lo_en = le; hi_en = he; lo_inc = li; hi_inc = hi; req = r;
  endtask

  initial begin
    int lows[4];
    int highs[4];
    lows  = '{697, 770, 852, 941};
    highs = '{1209, 1336, 1477, 1633};
    void'($urandom(32'd20417));
    set_tones(1'b0, 1'b0, 16'h0, 16'h0, "R1");
    do_reset();
    // R5: both tones, full wrap of the slower accumulator
    set_tones(1'b1, 1'b1, inc_of(697), inc_of(1633), "R5");
    run_ticks(150);
    // R6: low tone alone, R3: high phase frozen meanwhile
    set_tones(1'b1, 1'b0, inc_of(941), inc_of(1209), "R6 R3");
    run_ticks(110);
    set_tones(1'b0, 1'b1, inc_of(941), inc_of(1209), "R6 R3");
    run_ticks(90);
    // R7: nothing enabled
    set_tones(1'b0, 1'b0, inc_of(770), inc_of(1336), "R7");
    run_ticks(5);
    // R4: quarter-period steps hit peaks and zero crossings
    do_reset();
    set_tones(1'b1, 1'b0, 16'h4000, 16'h0, "R4 R6");
    run_ticks(6);
    set_tones(1'b1, 1'b1, 16'h4000, 16'h4000, "R4 R5");
    run_ticks(6);
    set_tones(1'b1, 1'b1, 16'h8000, 16'hC000, "R4 R5");
    run_ticks(6);
    set_tones(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, "R3 wrap");
    run_ticks(6);
    // R9: changes at random points between ticks
    for (int s = 0; s < 12; s++) begin
      repeat (1 + ($urandom % (DIV - 2))) step();
      set_tones(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), "R9");
      run_ticks(1);
    end
    // R1: reset in the middle of a period restarts phases
    repeat (57) step();
    do_reset();
    set_tones(1'b1, 1'b1, inc_of(852), inc_of(1477), "R1 R5");
    run_ticks(20);
    // Random keypad pairs mixed with random enables
    for (int s = 0; s < 20; s++) begin
      set_tones(($urandom % 4) != 0, ($urandom % 4) != 0,
                inc_of(lows[$urandom % 4]), inc_of(highs[$urandom % 4]), "R5 R6 random");
      run_ticks(10);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #950000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule